// File: doc/BRIEF.md
# Dual-Rail-Select Bundled-Data Multiplexer Controller

This block sequences a two-way merge of four-phase bundled-data push channels. Two data sources each offer a request, an acknowledge and a data bundle. A select channel carries one token per transfer on two request wires: one rail picks source 0 and the other rail picks source 1. Both rails share a single acknowledge. The controller reads the select token and waits for the matching source. It forwards that source's bundle on the output channel and then completes both the source handshake and the select handshake. The other source is left alone for the whole token.

The model is clocked: every handshake wire is sampled on the rising clock edge, and every output is a register. The choice made at the start of a token is kept in a state bit, so the return-to-zero phase releases the right source. The output data bundle is a register that is loaded when the output request rises. A select token that drives both rails at once is illegal. It sets a sticky error flag and starts no transfer.

Top module: `hs_bd_mux_ctl`

## Requirements
- R1: After reset, `out_req`, `src0_ack`, `src1_ack`, `pick_ack` and `proto_err` are all low.
- R2: `out_req` rises only after one select rail and the data request of the source it names have both been seen high. A data request without a select token, or a select token without its data request, never raises `out_req`.
- R3: The value on `out_data` equals the data of the selected source at the time `out_req` rises. It stays unchanged while `out_req` is high.
- R4: The acknowledge of the selected source rises only after `out_ack` has been seen high. `out_req` falls on the same clock edge.
- R5: `pick_ack` rises on the same clock edge as the acknowledge of the selected source.
- R6: The source that was not selected is never acknowledged, even while its request is held high during the token.
- R7: The selected source's acknowledge falls after its request is seen low. `pick_ack` falls only after the chosen select rail and `out_ack` are both seen low. It stays high while `out_ack` is still high.
- R8: `src0_ack` and `src1_ack` are never high together.
- R9: If `pick_lo_req` and `pick_hi_req` are seen high together, `proto_err` is set one cycle later and stays set until reset. No transfer starts from that state.
- R10: Encoding: a high `pick_lo_req` selects source 0 and a high `pick_hi_req` selects source 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| pick_lo_req | input | 1 | Select rail choosing source 0 |
| pick_hi_req | input | 1 | Select rail choosing source 1 |
| pick_ack | output | 1 | Shared select acknowledge |
| src0_req | input | 1 | Source 0 request |
| src0_ack | output | 1 | Source 0 acknowledge |
| src0_data | input | DW | Source 0 data bundle |
| src1_req | input | 1 | Source 1 request |
| src1_ack | output | 1 | Source 1 acknowledge |
| src1_data | input | DW | Source 1 data bundle |
| out_req | output | 1 | Output request |
| out_ack | input | 1 | Output acknowledge |
| out_data | output | DW | Output data bundle |
| proto_err | output | 1 | Sticky flag for both select rails high |

## Verification
On every cycle the assertions check the causal ordering rules. These are: output request only after a matching select and data request, a source acknowledge only after the output acknowledge, the select acknowledge moving with the data acknowledge and falling only once the output acknowledge is low, mutual exclusion of the two source acknowledges, output data holding steady, and the sticky error. Some properties are only visible over a whole token, and only the bench scenarios show them. These are that the forwarded values match the chosen sources in order, that a held-high unselected request stays unanswered, and that arrival order (select first or data first) does not change the result.

// File: rtl/hs_mux_pkg.sv
package hs_mux_pkg;
  typedef enum logic [1:0] {
    TK_IDLE  = 2'd0,
    TK_ARMED = 2'd1,
    TK_SEND  = 2'd2,
    TK_RTZ   = 2'd3
  } tok_state_e;

  localparam int unsigned NUM_SRC = 2;
endpackage

// File: rtl/hs_pick_decode.sv
module hs_pick_decode (
  input  logic clk,
  input  logic rst_n,
  input  logic pick_lo_req,
  input  logic pick_hi_req,
  output logic pick_valid,
  output logic pick_idx,
  output logic pick_err
);
  logic both_hi;
  logic err_q;
  logic err_d;

  assign both_hi    = pick_lo_req & pick_hi_req;
  assign pick_valid = pick_lo_req ^ pick_hi_req;
  assign pick_idx   = pick_hi_req;

  always_comb begin
    err_d = err_q;
    if (both_hi) begin
      err_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 1'b0;
    end else begin
      err_q <= err_d;
    end
  end

  assign pick_err = err_q;
endmodule

// File: rtl/hs_token_fsm.sv
module hs_token_fsm
  import hs_mux_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pick_valid,
  input  logic               pick_idx,
  input  logic               pick_lo_req,
  input  logic               pick_hi_req,
  input  logic [NUM_SRC-1:0] src_req,
  input  logic               out_ack,
  output logic [NUM_SRC-1:0] src_ack,
  output logic               pick_ack,
  output logic               out_req,
  output logic               choice,
  output logic               load_en
);
  tok_state_e        state_q, state_d;
  logic              choice_q, choice_d;
  logic              oreq_q, oreq_d;
  logic              pack_q, pack_d;
  logic [NUM_SRC-1:0] sack_q, sack_d;
  logic              chosen_rail;
  logic              chosen_req;

  assign chosen_rail = choice_q ? pick_hi_req : pick_lo_req;
  assign chosen_req  = src_req[choice_q];

  always_comb begin
    state_d  = state_q;
    choice_d = choice_q;
    oreq_d   = oreq_q;
    pack_d   = pack_q;
    sack_d   = sack_q;
    load_en  = 1'b0;
    unique case (state_q)
      TK_IDLE: begin
        if (pick_valid) begin
          choice_d = pick_idx;
          state_d  = TK_ARMED;
        end
      end
      TK_ARMED: begin
        if (chosen_req) begin
          load_en = 1'b1;
          oreq_d  = 1'b1;
          state_d = TK_SEND;
        end
      end
      TK_SEND: begin
        if (out_ack) begin
          oreq_d           = 1'b0;
          sack_d[choice_q] = 1'b1;
          pack_d           = 1'b1;
          state_d          = TK_RTZ;
        end
      end
      TK_RTZ: begin
        if (sack_q[choice_q] && !chosen_req) begin
          sack_d[choice_q] = 1'b0;
        end
        if (pack_q && !chosen_rail && !out_ack) begin
          pack_d = 1'b0;
        end
        if (!sack_q[choice_q] && !pack_q) begin
          state_d = TK_IDLE;
        end
      end
      default: state_d = TK_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= TK_IDLE;
      choice_q <= 1'b0;
      oreq_q   <= 1'b0;
      pack_q   <= 1'b0;
      sack_q   <= '0;
    end else begin
      state_q  <= state_d;
      choice_q <= choice_d;
      oreq_q   <= oreq_d;
      pack_q   <= pack_d;
      sack_q   <= sack_d;
    end
  end

  assign src_ack  = sack_q;
  assign pick_ack = pack_q;
  assign out_req  = oreq_q;
  assign choice   = choice_q;
endmodule

// File: rtl/hs_data_steer.sv
module hs_data_steer
  import hs_mux_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       load_en,
  input  logic                       choice,
  input  logic [NUM_SRC-1:0][DW-1:0] src_data,
  output logic [DW-1:0]              out_data
);
  logic [DW-1:0] hold_q;
  logic [DW-1:0] hold_d;
  logic [NUM_SRC-1:0][DW-1:0] masked;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_mask
    assign masked[g] = (choice == g[0]) ? src_data[g] : '0;
  end

  always_comb begin
    hold_d = hold_q;
    if (load_en) begin
      hold_d = '0;
      for (int i = 0; i < NUM_SRC; i++) begin
        hold_d = hold_d | masked[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
    end else begin
      hold_q <= hold_d;
    end
  end

  assign out_data = hold_q;
endmodule

// File: rtl/hs_bd_mux_ctl.sv
module hs_bd_mux_ctl
  import hs_mux_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pick_lo_req,
  input  logic          pick_hi_req,
  output logic          pick_ack,
  input  logic          src0_req,
  output logic          src0_ack,
  input  logic [DW-1:0] src0_data,
  input  logic          src1_req,
  output logic          src1_ack,
  input  logic [DW-1:0] src1_data,
  output logic          out_req,
  input  logic          out_ack,
  output logic [DW-1:0] out_data,
  output logic          proto_err
);
  logic                       pick_valid;
  logic                       pick_idx;
  logic                       choice;
  logic                       load_en;
  logic [NUM_SRC-1:0]         req_vec;
  logic [NUM_SRC-1:0]         ack_vec;
  logic [NUM_SRC-1:0][DW-1:0] data_vec;

  assign req_vec  = {src1_req, src0_req};
  assign data_vec = {src1_data, src0_data};
  assign src0_ack = ack_vec[0];
  assign src1_ack = ack_vec[1];

  hs_pick_decode u_decode (
    .clk         (clk),
    .rst_n       (rst_n),
    .pick_lo_req (pick_lo_req),
    .pick_hi_req (pick_hi_req),
    .pick_valid  (pick_valid),
    .pick_idx    (pick_idx),
    .pick_err    (proto_err)
  );

  hs_token_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .pick_valid  (pick_valid),
    .pick_idx    (pick_idx),
    .pick_lo_req (pick_lo_req),
    .pick_hi_req (pick_hi_req),
    .src_req     (req_vec),
    .out_ack     (out_ack),
    .src_ack     (ack_vec),
    .pick_ack    (pick_ack),
    .out_req     (out_req),
    .choice      (choice),
    .load_en     (load_en)
  );

  hs_data_steer #(.DW(DW)) u_steer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_en  (load_en),
    .choice   (choice),
    .src_data (data_vec),
    .out_data (out_data)
  );
endmodule

// File: rtl/hs_bd_mux_ctl_chk.sv
module hs_bd_mux_ctl_chk #(
  parameter int unsigned DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pick_lo_req,
  input logic          pick_hi_req,
  input logic          pick_ack,
  input logic          src0_req,
  input logic          src0_ack,
  input logic          src1_req,
  input logic          src1_ack,
  input logic          out_req,
  input logic          out_ack,
  input logic [DW-1:0] out_data,
  input logic          proto_err
);
  a_r2_out_req_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_req) |-> $past((pick_lo_req && src0_req) || (pick_hi_req && src1_req)));

  a_r3_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_req && $past(out_req)) |-> $stable(out_data));

  a_r4_ack0_after_out: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(src0_ack) |-> ($past(out_ack) && !out_req));

  a_r4_ack1_after_out: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(src1_ack) |-> ($past(out_ack) && !out_req));

  a_r5_pick_ack_with_data: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pick_ack) |-> ($rose(src0_ack) || $rose(src1_ack)));

  a_r10_src0_needs_lo: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(src0_ack) |-> !$past(pick_hi_req));

  a_r10_src1_needs_hi: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(src1_ack) |-> !$past(pick_lo_req));

  a_r7_pick_ack_release: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pick_ack) |-> $past(!out_ack));

  a_r8_ack_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(src0_ack && src1_ack));

  a_r9_err_set: assert property (@(posedge clk) disable iff (!rst_n)
    (pick_lo_req && pick_hi_req) |=> proto_err);

  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> proto_err);
endmodule

bind hs_bd_mux_ctl hs_bd_mux_ctl_chk #(.DW(DW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .pick_lo_req (pick_lo_req),
  .pick_hi_req (pick_hi_req),
  .pick_ack    (pick_ack),
  .src0_req    (src0_req),
  .src0_ack    (src0_ack),
  .src1_req    (src1_req),
  .src1_ack    (src1_ack),
  .out_req     (out_req),
  .out_ack     (out_ack),
  .out_data    (out_data),
  .proto_err   (proto_err)
);

// File: tb/hs_bd_mux_ctl_bench.sv
module hs_bd_mux_ctl_bench;
  localparam int unsigned DW = 8;

  logic          clk;
  logic          rst_n;
  logic          pick_lo_req, pick_hi_req, pick_ack;
  logic          src0_req, src0_ack, src1_req, src1_ack;
  logic [DW-1:0] src0_data, src1_data, out_data;
  logic          out_req, out_ack, proto_err;

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] exp_q[$];

  hs_bd_mux_ctl #(.DW(DW)) u_hs_bd_mux_ctl (
    .clk(clk), .rst_n(rst_n),
    .pick_lo_req(pick_lo_req), .pick_hi_req(pick_hi_req), .pick_ack(pick_ack),
    .src0_req(src0_req), .src0_ack(src0_ack), .src0_data(src0_data),
    .src1_req(src1_req), .src1_ack(src1_ack), .src1_data(src1_data),
    .out_req(out_req), .out_ack(out_ack), .out_data(out_data),
    .proto_err(proto_err)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input int actual, input int expected);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, actual, expected);
    end
  endtask

  // id: 0 out_req, 1 src0_ack, 2 src1_ack, 3 pick_ack
  function automatic logic probe(input int id);
    case (id)
      0: return out_req;
      1: return src0_ack;
      2: return src1_ack;
      default: return pick_ack;
    endcase
  endfunction

  task automatic wait_for(input int id, input logic val, input string req);
    int n = 0;
    while (probe(id) !== val && n < 50) begin
      @(negedge clk);
      n++;
    end
    check(probe(id) === val, req, $sformatf("wait signal %0d", id), int'(probe(id)), int'(val));
  endtask

  task automatic idle_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic apply_reset();
    rst_n = 1'b0;
    pick_lo_req = 0; pick_hi_req = 0; src0_req = 0; src1_req = 0;
    src0_data = '0; src1_data = '0; out_ack = 0;
    idle_cycles(3);
    rst_n = 1'b1;
    idle_cycles(1);
  endtask

  task automatic test_reset();
    apply_reset();
    check({out_req, src0_ack, src1_ack, pick_ack, proto_err} == 5'b0, "R1",
          "outputs after reset", int'({out_req, src0_ack, src1_ack, pick_ack, proto_err}), 0);
  endtask

  // order: 0 select first, 1 data first
  task automatic run_token(input bit pick, input bit order, input logic [DW-1:0] d0,
                           input logic [DW-1:0] d1, input bit other_hi);
    int sel_id = pick ? 2 : 1;
    int oth_id = pick ? 1 : 2;
    src0_data = d0; src1_data = d1;
    exp_q.push_back(pick ? d1 : d0);
    if (other_hi) begin
      if (pick) src0_req = 1; else src1_req = 1;
    end
    if (order == 0) begin
      if (pick) pick_hi_req = 1; else pick_lo_req = 1;
      idle_cycles(4);
      check(out_req == 0, "R2", "out_req with select only", int'(out_req), 0);
      if (pick) src1_req = 1; else src0_req = 1;
    end else begin
      if (pick) src1_req = 1; else src0_req = 1;
      idle_cycles(4);
      check(out_req == 0, "R2", "out_req with data only", int'(out_req), 0);
      if (pick) pick_hi_req = 1; else pick_lo_req = 1;
    end
    wait_for(0, 1'b1, "R2");
    begin
      logic [DW-1:0] e = exp_q.pop_front();
      check(out_data == e, "R3", "out_data on out_req rise", int'(out_data), int'(e));
      idle_cycles(3);
      check(probe(sel_id) == 0, "R4", "source ack before out_ack", int'(probe(sel_id)), 0);
      check(out_data == e, "R3", "out_data held", int'(out_data), int'(e));
    end
    out_ack = 1;
    wait_for(sel_id, 1'b1, "R4");
    check(out_req == 0, "R4", "out_req low with source ack", int'(out_req), 0);
    check(pick_ack == 1, "R5", "pick_ack with source ack", int'(pick_ack), 1);
    if (pick) src1_req = 0; else src0_req = 0;
    pick_lo_req = 0; pick_hi_req = 0;
    wait_for(sel_id, 1'b0, "R7");
    idle_cycles(3);
    check(pick_ack == 1, "R7", "pick_ack held while out_ack high", int'(pick_ack), 1);
    out_ack = 0;
    wait_for(3, 1'b0, "R7");
    check(probe(oth_id) == 0, "R6", "unselected source ack", int'(probe(oth_id)), 0);
    src0_req = 0; src1_req = 0;
    idle_cycles(2);
  endtask

  task automatic test_directed();
    run_token(1'b0, 1'b0, 8'h3C, 8'hA5, 1'b0);  // R10 low rail -> source 0
    run_token(1'b1, 1'b1, 8'h11, 8'hE7, 1'b0);  // R10 high rail -> source 1
    run_token(1'b0, 1'b1, 8'h5A, 8'hFF, 1'b1);  // R6 source 1 held high
    run_token(1'b1, 1'b0, 8'h00, 8'h81, 1'b1);  // R6 source 0 held high
  endtask

  task automatic test_random();
    for (int i = 0; i < 20; i++) begin
      run_token(1'($urandom), 1'($urandom), 8'($urandom), 8'($urandom), 1'($urandom));
    end
    check(exp_q.size() == 0, "R3", "reference queue drained", exp_q.size(), 0);
  endtask

  task automatic test_both_rails();
    pick_lo_req = 1; pick_hi_req = 1;
    idle_cycles(2);
    check(proto_err == 1, "R9", "error flag after both rails", int'(proto_err), 1);
    src0_req = 1; src1_req = 1;
    idle_cycles(5);
    check(out_req == 0, "R9", "no transfer on illegal select", int'(out_req), 0);
    check({src0_ack, src1_ack, pick_ack} == 3'b0, "R8", "no acks on illegal select",
          int'({src0_ack, src1_ack, pick_ack}), 0);
    pick_lo_req = 0; pick_hi_req = 0; src0_req = 0; src1_req = 0;
    idle_cycles(3);
    check(proto_err == 1, "R9", "error flag sticky", int'(proto_err), 1);
    apply_reset();
    check(proto_err == 0, "R1", "error cleared by reset", int'(proto_err), 0);
  endtask

  initial begin
    test_reset();
    test_directed();
    test_random();
    test_both_rails();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule